// File: doc/BRIEF.md
# Self-Synchronizing Display Command Receiver

This block listens, receive-only, to the serial command stream a host controller sends to an LED display driver, and rebuilds the driver's 8-byte display memory from it. It never drives the bus and never issues reads. The stream reaches it through inverting isolators, so every assembled byte is complemented before it is looked at. There is no chip-select framing: the strobe line is not brought into the block at all.

Byte boundaries are recovered from two sources. The first is the content of the stream: only an address-set command has both of its top bits high, and the byte that follows it is the data for that address. The second is a silence timeout: when no serial clock edge has been seen for a configurable number of microseconds, the bit counter and the pending address are discarded. A stream misaligned by stray bits therefore heals at the next pause, and the host repeats its whole frame every few milliseconds. Each stored byte raises a one-cycle update pulse for its entry. Timeouts are counted, and an address beyond the memory raises a sticky error flag.

Top module: `disp_cmd_snoop`

## Requirements
- R1: While and right after reset, all memory entries read 0, no update pulse is high, the timeout count is 0 and the error flag is 0.
- R2: Serial bits are taken at each rising edge of the serial clock, least significant bit first; eight bits form one byte, which is bit-inverted before decoding.
- R3: A decoded byte whose bits 7 and 6 are both 1 is an address command whose bits 5:0 name the target entry; it arms exactly one following data byte, and a second data byte without a new address command is ignored.
- R4: A decoded byte with bits 7:6 equal to 00 that follows an armed in-range address is written to that entry, and the entry's bit of the update vector (bit i for entry i) is high for exactly one cycle while all other entries keep their values.
- R5: Decoded bytes with bits 7:6 equal to 01 or 10 (for example 0x44 and 0x8B) and data bytes with no armed address change no memory entry; a 01/10 byte between an address command and its data cancels the armed address.
- R6: When TIMEOUT_US microseconds pass after the last serial clock edge, the timeout count rises by exactly one; there is no further count until serial activity resumes, and none before the first edge after reset.
- R7: A timeout clears the partial bit count, so a stream broken by stray bits decodes correctly from its next byte.
- R8: An address command naming an entry of 8 or more sets the error flag, which stays set until reset, and the data byte after it is discarded.
- R9: A timeout drops an armed address, so a data byte arriving after the pause is not stored.
- R10: A repeated host frame of mode, write-setting, address, data and display-control bytes updates every entry it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock as seen after the isolator, asynchronous |
| ser_din | input | 1 | Serial data as seen after the isolator (inverted), asynchronous |
| mem_flat | output | DEPTH*8 | Display memory, entry i at bits [8*i+7:8*i] |
| upd | output | DEPTH | One-cycle write pulse per entry |
| timeout_cnt | output | CNT_W | Number of silence timeouts, wraps |
| err | output | 1 | Sticky out-of-range address flag |

## Verification
The main function is driven with single address/data pairs, with the full five-byte host frame over all eight entries, with control bytes and orphan data interleaved, and with an address command split from its data by a pause; these separate correct storage from storage into the wrong entry, from decoding of commands that must be ignored and from a pending address surviving a timeout. A burst of stray bits followed by a pause shows that realignment comes from the timeout and not from luck. An out-of-range address distinguishes a discarded data byte from one written into a truncated address. A scoreboard pairs every update pulse with the entry and value the bench expects.

// File: rtl/disp_snoop_pkg.sv
package disp_snoop_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_DATA = 2'b00,
    CLS_CTRL = 2'b01,
    CLS_ADDR = 2'b11
  } byte_cls_e;

  function automatic byte_cls_e classify(input logic [BYTE_W-1:0] b);
    case (b[7:6])
      2'b00:   classify = CLS_DATA;
      2'b11:   classify = CLS_ADDR;
      default: classify = CLS_CTRL;
    endcase
  endfunction
endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/snoop_shifter.sv
module snoop_shifter
  import disp_snoop_pkg::*;
#(
  parameter int TIMEOUT_US = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              tick,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              tmo
);
  localparam int BC_W   = $clog2(BYTE_W);
  localparam int IDLE_W = $clog2(TIMEOUT_US + 1);

  logic              sclk_d;
  logic              rise;
  logic [BC_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sh_next;
  logic [IDLE_W-1:0] idle;
  logic              armed;

  assign rise    = sclk_s & ~sclk_d;
  assign sh_next = {din_s, sh[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      bit_cnt  <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      idle     <= '0;
      armed    <= 1'b0;
      tmo      <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      byte_vld <= 1'b0;
      tmo      <= 1'b0;
      if (rise) begin
        sh    <= sh_next;
        armed <= 1'b1;
        idle  <= '0;
        if (bit_cnt == BC_W'(BYTE_W - 1)) begin
          bit_cnt  <= '0;
          byte_vld <= 1'b1;
          byte_q   <= ~sh_next;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (armed && tick) begin
        if (idle == IDLE_W'(TIMEOUT_US - 1)) begin
          tmo     <= 1'b1;
          armed   <= 1'b0;
          bit_cnt <= '0;
          idle    <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/snoop_decoder.sv
module snoop_decoder
  import disp_snoop_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     byte_vld,
  input  logic [BYTE_W-1:0]        byte_q,
  input  logic                     tmo,
  output logic [DEPTH*BYTE_W-1:0]  mem_flat,
  output logic [DEPTH-1:0]         upd,
  output logic                     err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [5:0] DEPTH6 = 6'(DEPTH);

  byte_cls_e         cls;
  logic              pend;
  logic [AW-1:0]     paddr;
  logic              do_wr;
  logic [BYTE_W-1:0] mem_q [DEPTH];

  assign cls   = classify(byte_q);
  assign do_wr = byte_vld && (cls == CLS_DATA) && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      paddr <= '0;
      err   <= 1'b0;
    end else if (tmo) begin
      pend <= 1'b0;
    end else if (byte_vld) begin
      if (cls == CLS_ADDR) begin
        if (byte_q[5:0] < DEPTH6) begin
          pend  <= 1'b1;
          paddr <= byte_q[AW-1:0];
        end else begin
          pend <= 1'b0;
          err  <= 1'b1;
        end
      end else begin
        pend <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_q[i] <= '0;
        upd[i]   <= 1'b0;
      end else begin
        upd[i] <= do_wr && (paddr == AW'(i));
        if (do_wr && (paddr == AW'(i)))
          mem_q[i] <= byte_q;
      end
    end
    assign mem_flat[i*BYTE_W +: BYTE_W] = mem_q[i];
  end
endmodule

// File: rtl/disp_cmd_snoop.sv
module disp_cmd_snoop
  import disp_snoop_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_US = 1000,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ser_clk,
  input  logic                    ser_din,
  output logic [DEPTH*BYTE_W-1:0] mem_flat,
  output logic [DEPTH-1:0]        upd,
  output logic [CNT_W-1:0]        timeout_cnt,
  output logic                    err
);
  localparam int TICK_DIV = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int DIV_W    = $clog2(TICK_DIV + 1);

  logic [1:0]        ser_s;
  logic [DIV_W-1:0]  div_cnt;
  logic              tick;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;
  logic              tmo;

  snoop_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk, ser_din}),
    .q   (ser_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt == DIV_W'(TICK_DIV - 1)) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick    <= 1'b0;
    end
  end

  snoop_shifter #(.TIMEOUT_US(TIMEOUT_US)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (ser_s[1]),
    .din_s    (ser_s[0]),
    .tick     (tick),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .tmo      (tmo)
  );

  snoop_decoder #(.DEPTH(DEPTH)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .tmo      (tmo),
    .mem_flat (mem_flat),
    .upd      (upd),
    .err      (err)
  );

  always_ff @(posedge clk) begin
    if (rst)
      timeout_cnt <= '0;
    else if (tmo)
      timeout_cnt <= timeout_cnt + 1'b1;
  end
endmodule

// File: rtl/disp_cmd_snoop_chk.sv
module disp_cmd_snoop_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [DEPTH*8-1:0]     mem_flat,
  input logic [DEPTH-1:0]       upd,
  input logic [CNT_W-1:0]       timeout_cnt,
  input logic                   err
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d) begin
      a_r1_reset_clear: assert (timeout_cnt == '0 && err == 1'b0 && upd == '0 && mem_flat == '0);
    end
  end

  a_r4_upd_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(upd));

  a_r4_upd_single: assert property (@(posedge clk) disable iff (rst) (upd != '0) |=> (upd == '0));

  a_r4_mem_quiet: assert property (@(posedge clk) disable iff (rst) (upd == '0) |-> $stable(mem_flat));

  a_r6_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (timeout_cnt != $past(timeout_cnt)) |-> (timeout_cnt == $past(timeout_cnt) + 1'b1));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);
endmodule

bind disp_cmd_snoop disp_cmd_snoop_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_flat    (mem_flat),
  .upd         (upd),
  .timeout_cnt (timeout_cnt),
  .err         (err)
);

// File: tb/test_disp_cmd_snoop.sv
module test_disp_cmd_snoop;
  localparam int DEPTH = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b1;
  logic [DEPTH*8-1:0] mem_flat;
  logic [DEPTH-1:0]   upd;
  logic [CNT_W-1:0]   timeout_cnt;
  logic               err;

  always #5 clk = ~clk;

  disp_cmd_snoop #(
    .CLK_HZ(10_000_000), .TIMEOUT_US(20), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) i_disp_cmd_snoop (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .mem_flat(mem_flat), .upd(upd), .timeout_cnt(timeout_cnt), .err(err)
  );

  int checks = 0;
  int failures = 0;
  int exp_to = 0;
  logic [7:0] model [DEPTH];
  logic [10:0] expq [$];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard monitor: every update pulse must match the queue head (R4)
  always @(negedge clk) begin
    if (!rst && upd != '0) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected update", int'(upd), 0);
      end else begin
        logic [10:0] e;
        e = expq.pop_front();
        chk(upd == (DEPTH'(1) << e[10:8]), "R4 update entry", int'(upd), int'(DEPTH'(1) << e[10:8]));
        chk(mem_flat[e[10:8]*8 +: 8] == e[7:0], "R4 stored value",
            int'(mem_flat[e[10:8]*8 +: 8]), int'(e[7:0]));
      end
    end
  end

  task automatic send_bits(input logic [7:0] wire_val, input int n);
    for (int i = 0; i < n; i++) begin
      ser_din = wire_val[i];
      repeat (3) @(posedge clk);
      ser_clk = 1'b1;
      repeat (3) @(posedge clk);
      ser_clk = 1'b0;
      repeat (2) @(posedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(~b, 8);
    repeat (6) @(posedge clk);
  endtask

  task automatic store(input int a, input logic [7:0] d);
    send_byte(8'hC0 | 8'(a));
    expq.push_back({3'(a), d});
    model[a] = d;
    send_byte(d);
  endtask

  task automatic go_idle();
    repeat (400) @(posedge clk);
    exp_to++;
  endtask

  task automatic check_mem(input string tag);
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++)
      chk(mem_flat[a*8 +: 8] == model[a], tag, int'(mem_flat[a*8 +: 8]), int'(model[a]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(mem_flat == '0 && upd == '0, "R1 reset memory", int'(mem_flat[31:0]), 0);
    chk(timeout_cnt == '0 && err == 1'b0, "R1 reset count/err", int'(timeout_cnt), 0);
    rst = 1'b0;

    // R6: no timeout before any serial edge
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk(timeout_cnt == 0, "R6 no timeout before activity", int'(timeout_cnt), 0);

    // R2, R4: single pair, inverted LSB-first wire bits
    store(3, 8'h2A);
    go_idle();
    check_mem("R2 inverted LSB-first byte stored");
    chk(int'(timeout_cnt) == exp_to, "R6 one timeout per pause", int'(timeout_cnt), exp_to);
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk(int'(timeout_cnt) == exp_to, "R6 no repeat timeout", int'(timeout_cnt), exp_to);

    // R10: full host frame across all entries
    for (int a = 0; a < DEPTH; a++) begin
      send_byte(8'h00);
      send_byte(8'h44);
      store(a, 8'((a * 9 + 5) & 'h3F));
      send_byte(8'h8B);
    end
    go_idle();
    check_mem("R10 frame updates all entries");

    // R3: second data byte without new address ignored
    store(1, 8'h11);
    send_byte(8'h22);
    go_idle();
    check_mem("R3 fixed addressing");

    // R5: control bytes and orphan data; control cancels pending address
    send_byte(8'h00);
    send_byte(8'h44);
    send_byte(8'h8B);
    send_byte(8'h3F);
    send_byte(8'hC2);
    send_byte(8'h44);
    send_byte(8'h15);
    go_idle();
    check_mem("R5 ignored bytes");

    // R8: out-of-range address
    chk(err == 1'b0, "R8 err clear before", int'(err), 0);
    send_byte(8'hC9);
    send_byte(8'h07);
    go_idle();
    @(negedge clk);
    chk(err == 1'b1, "R8 err set", int'(err), 1);
    check_mem("R8 data discarded");
    store(4, 8'h19);
    go_idle();
    check_mem("R8 later store works");
    chk(err == 1'b1, "R8 err sticky", int'(err), 1);

    // R9: pause between address and data
    send_byte(8'hC5);
    go_idle();
    send_byte(8'h33);
    go_idle();
    check_mem("R9 pending dropped by timeout");

    // R7: stray bits, pause, then clean pair
    send_bits(8'h00, 3);
    go_idle();
    store(6, 8'h2C);
    go_idle();
    check_mem("R7 realigned after timeout");
    chk(int'(timeout_cnt) == exp_to, "R6 timeout total", int'(timeout_cnt), exp_to);
    chk(expq.size() == 0, "R4 all expected updates seen", expq.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule